// File: doc/BRIEF.md
# Ring Free-Space Monitor with Stall Watchdog

This block watches a circular command ring in which a producer appends at a tail offset and a consumer drains from a head offset. It reports the writable byte count at all times and keeps a fixed guard gap of 8 bytes, so the tail can never catch the head. It also flags an empty ring.

A client asks for a number of bytes, or asks for a full drain. The monitor then polls at an interval set by a programmable prescaler. It pulses a success strobe as soon as enough space exists. While it waits, a stall counter counts polls in which neither the head offset nor a separate active-execution pointer has changed. Any movement of either one restarts the count. The request is abandoned with a busy error only when the consumer has made no progress for a whole limit of polls.

Top module: `ring_space_monitor`

## Requirements
- R1: `freeSpace` equals (head − tail − 8) modulo the ring size. Ring size is 2^`ringLog2`, with `ringLog2` between 4 and PTR_W. Head and tail are first masked to their low `ringLog2` bits. The output is combinational.
- R2: `ringEmpty` is high exactly when the masked head equals the masked tail.
- R3: A request is taken only while idle. `reqValid` latches `reqBytes` as the need. `drainReq` latches ring size − 8 as the need and wins when both are high. A request raised while one is pending is ignored.
- R4: A poll occurs every `pollDiv`+1 cycles, the first one `pollDiv`+1 cycles after acceptance. If `freeSpace` ≥ need at a poll, `doneOk` is high for one cycle in the following cycle, and `waiting` drops in that same cycle.
- R5: At a poll without enough space, the stall count returns to zero if the masked head differs from its value at the previous poll (or at acceptance).
- R6: The stall count also returns to zero if `actHead` differs from its value at the previous poll (or at acceptance).
- R7: After STALL_LIMIT consecutive polls with neither enough space nor progress, `busyErr` is high for one cycle and `waiting` drops.
- R8: `waiting` is high from the cycle after acceptance until the cycle in which `doneOk` or `busyErr` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| headPtr | input | PTR_W | Consumer byte offset |
| tailPtr | input | PTR_W | Producer byte offset |
| actHead | input | ACT_W | Active-execution progress pointer |
| ringLog2 | input | LOG_W | Log2 of ring size in bytes |
| pollDiv | input | DIV_W | Poll interval minus one, in cycles |
| reqValid | input | 1 | Start a wait for `reqBytes` |
| reqBytes | input | PTR_W+1 | Bytes needed |
| drainReq | input | 1 | Start a wait for a fully drained ring |
| freeSpace | output | PTR_W | Writable bytes |
| ringEmpty | output | 1 | Head equals tail |
| waiting | output | 1 | Request pending |
| doneOk | output | 1 | Request satisfied pulse |
| busyErr | output | 1 | Stall timeout pulse |

## Verification
The bench drives pointer pairs where tail is ahead of head and behind it, including set bits above the ring mask, so a design that forgets to wrap or mask reports huge or wrong space. It keeps a wait alive past the stall limit by moving only the head, and then by moving only the active pointer. A design that ignores either movement times out early, and one that never counts times out never. It also fires a second request while one is pending and a drain on a non-empty ring. A design that re-latches the need, or computes the drain need without the guard, finishes in the wrong cycle.

// File: rtl/ring_mon_pkg.sv
package ring_mon_pkg;
  typedef struct packed {
    logic loadReq;     // latch need and first progress samples
    logic takeSample;  // refresh progress samples at a poll
  } ringStrobe_t;

  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } monState_t;
endpackage

// File: rtl/ring_space_path.sv
module ring_space_path
  import ring_mon_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int ACT_W = 32,
  parameter int GUARD = 8,
  localparam int LOG_W = $clog2(PTR_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      strb,
  input  logic             drainSel,
  input  logic [PTR_W:0]   reqBytes,
  input  logic [PTR_W-1:0] headPtr,
  input  logic [PTR_W-1:0] tailPtr,
  input  logic [ACT_W-1:0] actHead,
  input  logic [LOG_W-1:0] ringLog2,
  output logic [PTR_W-1:0] freeSpace,
  output logic             ringEmpty,
  output logic             spaceOk,
  output logic             moved
);
  logic [PTR_W:0]   sizeVal;
  logic [PTR_W-1:0] ptrMask;
  logic [PTR_W-1:0] headM;
  logic [PTR_W-1:0] tailM;
  logic [PTR_W-1:0] rawDiff;
  logic [PTR_W:0]   needBytes;
  logic [PTR_W-1:0] lastHead;
  logic [ACT_W-1:0] lastAct;

  always_comb begin
    sizeVal   = (PTR_W+1)'(1) << ringLog2;
    ptrMask   = PTR_W'(sizeVal - 1'b1);
    headM     = headPtr & ptrMask;
    tailM     = tailPtr & ptrMask;
    rawDiff   = headM - tailM - PTR_W'(GUARD);
    freeSpace = rawDiff & ptrMask;
    ringEmpty = (headM == tailM);
    spaceOk   = ({1'b0, freeSpace} >= needBytes);
    moved     = (headM != lastHead) || (actHead != lastAct);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      needBytes <= '0;
      lastHead  <= '0;
      lastAct   <= '0;
    end else begin
      if (strb.loadReq)
        needBytes <= drainSel ? (sizeVal - (PTR_W+1)'(GUARD)) : reqBytes;
      if (strb.loadReq || strb.takeSample) begin
        lastHead <= headM;
        lastAct  <= actHead;
      end
    end
  end

  p_empty_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    ringEmpty |-> ({1'b0, freeSpace} == sizeVal - (PTR_W+1)'(GUARD)));

  p_no_move_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.takeSample) && $past(rstN) && $stable(headPtr) && $stable(actHead)
      && $stable(ringLog2)) |-> !moved);
endmodule

// File: rtl/ring_wait_ctrl.sv
module ring_wait_ctrl
  import ring_mon_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int STALL_LIMIT = 100000,
  localparam int STALL_W    = $clog2(STALL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             drainReq,
  input  logic [DIV_W-1:0] pollDiv,
  input  logic             spaceOk,
  input  logic             moved,
  output ringStrobe_t      strb,
  output logic             doneOk,
  output logic             busyErr,
  output logic             waiting
);
  monState_t        state;
  logic [DIV_W-1:0] preCnt;
  logic [STALL_W-1:0] stallCnt;
  logic             pollTick;

  assign pollTick = (state == ST_WAIT) && (preCnt == pollDiv);
  assign waiting  = (state == ST_WAIT);

  always_comb begin
    strb.loadReq    = (state == ST_IDLE) && (reqValid || drainReq);
    strb.takeSample = pollTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      preCnt   <= '0;
      stallCnt <= '0;
      doneOk   <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      doneOk  <= 1'b0;
      busyErr <= 1'b0;
      if (state == ST_IDLE) begin
        if (reqValid || drainReq) begin
          state    <= ST_WAIT;
          preCnt   <= '0;
          stallCnt <= '0;
        end
      end else if (pollTick) begin
        preCnt <= '0;
        if (spaceOk) begin
          doneOk <= 1'b1;
          state  <= ST_IDLE;
        end else if (moved) begin
          stallCnt <= '0;
        end else if (stallCnt == STALL_W'(STALL_LIMIT - 1)) begin
          busyErr <= 1'b1;
          state   <= ST_IDLE;
        end else begin
          stallCnt <= stallCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  p_done_ends_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> ($past(waiting) && !waiting));

  p_err_needs_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> ($past(!spaceOk) && !waiting && !doneOk));

  p_wait_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> $past(reqValid || drainReq));
endmodule

// File: rtl/ring_space_monitor.sv
module ring_space_monitor
  import ring_mon_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int ACT_W       = 32,
  parameter int DIV_W       = 8,
  parameter int STALL_LIMIT = 100000,
  localparam int LOG_W      = $clog2(PTR_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] headPtr,
  input  logic [PTR_W-1:0] tailPtr,
  input  logic [ACT_W-1:0] actHead,
  input  logic [LOG_W-1:0] ringLog2,
  input  logic [DIV_W-1:0] pollDiv,
  input  logic             reqValid,
  input  logic [PTR_W:0]   reqBytes,
  input  logic             drainReq,
  output logic [PTR_W-1:0] freeSpace,
  output logic             ringEmpty,
  output logic             waiting,
  output logic             doneOk,
  output logic             busyErr
);
  ringStrobe_t strb;
  logic        spaceOk;
  logic        moved;

  ring_space_path #(.PTR_W(PTR_W), .ACT_W(ACT_W), .GUARD(8)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .drainSel(drainReq),
    .reqBytes(reqBytes), .headPtr(headPtr), .tailPtr(tailPtr),
    .actHead(actHead), .ringLog2(ringLog2), .freeSpace(freeSpace),
    .ringEmpty(ringEmpty), .spaceOk(spaceOk), .moved(moved)
  );

  ring_wait_ctrl #(.DIV_W(DIV_W), .STALL_LIMIT(STALL_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .drainReq(drainReq),
    .pollDiv(pollDiv), .spaceOk(spaceOk), .moved(moved), .strb(strb),
    .doneOk(doneOk), .busyErr(busyErr), .waiting(waiting)
  );
endmodule

// File: tb/tb_ring_space_monitor.sv
`timescale 1ns/1ps
module tb_ring_space_monitor;
  localparam int PTR_W = 12;
  localparam int ACT_W = 16;
  localparam int DIV_W = 4;
  localparam int LIM   = 5;
  localparam int LOG_W = $clog2(PTR_W + 1);

  logic clk = 0, rstN = 0;
  logic [PTR_W-1:0] headPtr = '0, tailPtr = '0;
  logic [ACT_W-1:0] actHead = '0;
  logic [LOG_W-1:0] ringLog2 = LOG_W'(8);
  logic [DIV_W-1:0] pollDiv = DIV_W'(2);
  logic reqValid = 0, drainReq = 0;
  logic [PTR_W:0] reqBytes = '0;
  logic [PTR_W-1:0] freeSpace;
  logic ringEmpty, waiting, doneOk, busyErr;

  int tests = 0, fails = 0, cyc = 0;

  ring_space_monitor #(.PTR_W(PTR_W), .ACT_W(ACT_W), .DIV_W(DIV_W), .STALL_LIMIT(LIM)) dut (
    .clk(clk), .rstN(rstN), .headPtr(headPtr), .tailPtr(tailPtr), .actHead(actHead),
    .ringLog2(ringLog2), .pollDiv(pollDiv), .reqValid(reqValid), .reqBytes(reqBytes),
    .drainReq(drainReq), .freeSpace(freeSpace), .ringEmpty(ringEmpty),
    .waiting(waiting), .doneOk(doneOk), .busyErr(busyErr));

  always #2 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int mWait = 0, mPre = 0, mStall = 0, mNeed = 0, mLastH = 0, mLastA = 0;
  int mDone = 0, mErr = 0;

  function automatic int sizeOf();
    return 1 << ringLog2;
  endfunction
  function automatic int hM();
    return int'(headPtr) % sizeOf();
  endfunction
  function automatic int tM();
    return int'(tailPtr) % sizeOf();
  endfunction
  function automatic int freeRef();
    int d = hM() - tM() - 8;
    while (d < 0) d += sizeOf();
    return d % sizeOf();
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mWait = 0; mPre = 0; mStall = 0; mNeed = 0; mLastH = 0; mLastA = 0; mDone = 0; mErr = 0;
    end else begin
      mDone = 0; mErr = 0;
      if (mWait == 0) begin
        if (reqValid || drainReq) begin
          mWait = 1; mPre = 0; mStall = 0;
          mNeed = drainReq ? sizeOf() - 8 : int'(reqBytes);
          mLastH = hM(); mLastA = int'(actHead);
        end
      end else if (mPre == int'(pollDiv)) begin
        mPre = 0;
        if (freeRef() >= mNeed) begin mDone = 1; mWait = 0; end
        else if (hM() != mLastH || int'(actHead) != mLastA) mStall = 0;
        else if (mStall == LIM - 1) begin mErr = 1; mWait = 0; end
        else mStall++;
        mLastH = hM(); mLastA = int'(actHead);
      end else mPre++;
    end
  end

  always @(negedge clk) begin
    if (cyc > 1) begin
      check("R1 freeSpace", freeSpace, freeRef());
      check("R2 ringEmpty", ringEmpty, (hM() == tM()) ? 1 : 0);
      check("R3/R8 waiting", waiting, mWait);
      check("R4 doneOk", doneOk, mDone);
      check("R7 busyErr", busyErr, mErr);
    end
  end

  task automatic drive(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) drive(); endtask
  task automatic ask(int bytes, bit drain);
    drive(); reqValid = !drain; drainReq = drain; reqBytes = (PTR_W+1)'(bytes);
    drive(); reqValid = 0; drainReq = 0;
  endtask
  task automatic waitIdle();
    int n = 0;
    while (waiting && n < 500) begin drive(); n++; end
    idle(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    check("R8 reset waiting", waiting, 0);
    check("R4 reset doneOk", doneOk, 0);
    check("R7 reset busyErr", busyErr, 0);
    drive(); rstN = 1;
    idle(2);
    @(negedge clk);
    check("R1 empty ring free", freeSpace, 248);
    check("R2 empty flag", ringEmpty, 1);

    // immediate success
    ask(100, 0); waitIdle();

    // tail ahead of head, no progress: timeout
    drive(); headPtr = 12'h040; tailPtr = 12'h080;
    ask(200, 0); waitIdle();

    // R6: only the active pointer moves, wait outlives the limit
    ask(200, 0);
    for (int i = 0; i < 8; i++) begin idle(6); actHead = actHead + 1'b1; end
    @(negedge clk); check("R6 still waiting", waiting, 1);
    waitIdle();

    // R5: only head moves, then space appears
    ask(200, 0);
    for (int i = 0; i < 8; i++) begin idle(6); headPtr = headPtr + 1'b1; end
    @(negedge clk); check("R5 still waiting", waiting, 1);
    drive(); headPtr = 12'h050;
    waitIdle();

    // R3: second request while pending is ignored
    drive(); headPtr = 12'h000; tailPtr = 12'h0F0;
    ask(250, 0); ask(1, 0); ask(1, 1);
    @(negedge clk); check("R3 ignored request", waiting, 1);
    waitIdle();

    // drain: non-empty then catch up
    drive(); headPtr = 12'h010; tailPtr = 12'h030;
    ask(0, 1); idle(4); headPtr = 12'h030; waitIdle();
    // drain on empty ring finishes at first poll
    ask(0, 1); waitIdle();

    // larger ring, bits above mask, slow polls
    drive(); ringLog2 = LOG_W'(10); pollDiv = DIV_W'(5);
    headPtr = 12'hC08; tailPtr = 12'h410;
    idle(1);
    @(negedge clk); check("R1 masked wrap", freeSpace, 1008);
    ask(1008, 0); waitIdle();
    ask(1009, 0); waitIdle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule